// File: doc/BRIEF.md
# Sticky Interrupt Pending Flag Bank

This block keeps one pending flag for each of 96 interrupt sources and lets software reach them through 32 word registers. Register m carries three flags, one at the bottom bit of each of its three low byte lanes. Lane 0 bit 0 is source m, lane 1 bit 8 is source m+32, and lane 2 bit 16 is source m+64. All remaining bits are reserved.

A hardware request pulse sets a flag. A software write of 1 into a flag position also sets it. A flag goes back to 0 only on reset or on a software write of 0. Taking the interrupt elsewhere never clears it.

The bus side is a plain register port with byte enables, so one lane or the whole word can be written. Reads come back one cycle later. The full 96-bit flag state is driven out every cycle, indexed by source number, for the masking and priority logic that sits downstream.

Top module: `irq_pend_bank`

## Requirements
- R1: While reset is asserted, and right after it, every flag is 0. The pending output and every register read return 0.
- R2: A one-cycle pulse on `hw_req[s]` sets flag s. Flag s appears on `pending[s]` in the cycle after the sampling edge. Register s mod 32 reports it at bit 8*(s div 32).
- R3: A set flag stays set across any number of cycles until reset or a software write of 0 to its bit. Nothing clears it by itself.
- R4: A write with `be[b]`=1 to register m loads `wdata` bit 8*b into the flag of source 32*b+m, for lanes b = 0, 1, 2. A 1 sets the flag and a 0 clears it.
- R5: Lanes whose byte enable is 0 keep their flags unchanged during a write.
- R6: When a hardware request and a software write of 0 reach the same flag in the same cycle, the flag ends up 1.
- R7: Reserved bits always read 0, and writing them has no effect. This covers bits 1-7, 9-15 and 17-23, and all of lane 3 including `be[3]`.
- R8: With `rd_en`=1 at an edge, `rdata` after that edge holds the addressed register as it was before the edge. `rdata` holds its value while `rd_en` is 0.
- R9: `pending[s]` equals the flag of source s at every cycle.
- R10: The register index is `addr[6:2]`, at byte offsets 0x00 to 0x7C. `addr[1:0]` is ignored. A write changes only the flags of the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | 96 | Hardware set pulses, one per source |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | Byte offset of the register |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte-lane write enables |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| pending | output | 96 | Current flags indexed by source number |

## Verification
The hardest case to reach is a hardware pulse and a software clear landing on the same flag in the same cycle. It must also happen while the other lanes of that register are masked off by their byte enables. A directed step aims a pulse and a clearing write at one source and checks that the neighbouring lanes keep their values. The random phase uses sparse per-source pulses, random partial byte enables and unaligned addresses, so the three-way collisions of set, clear and masked lane also occur many times without being aimed at.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
   localparam int LANE_W    = 8;
   localparam int MAX_LANES = 4;

   function automatic int flag_bit_pos(input int lane);
      return lane * LANE_W;
   endfunction

   function automatic int source_id(input int lane, input int reg_idx, input int num_regs);
      return lane * num_regs + reg_idx;
   endfunction
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic sw_we,
   input  logic sw_val,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag <= 1'b0;
      else if (hw_set) flag <= 1'b1;
      else if (sw_we)  flag <= sw_val;
   end

   // R6, R2: a hardware pulse always leaves the flag set
   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> flag);

   // R4: a software write without a competing request loads the bit
   p_sw_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && !hw_set) |=> (flag == $past(sw_val)));

   // R3: with no request and no write the flag is sticky
   p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_we && !hw_set) |=> $stable(flag));
endmodule

// File: rtl/irq_wr_decode.sv
module irq_wr_decode #(
   parameter int NUM_REGS  = 32,
   parameter int NUM_LANES = 3,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 7
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [DATA_W-1:0]             wdata,
   input  logic [DATA_W/8-1:0]           be,
   output logic [NUM_LANES*NUM_REGS-1:0] we_src,
   output logic [NUM_LANES*NUM_REGS-1:0] wval_src
);
   import irq_pend_pkg::*;
   localparam int IDX_W = $clog2(NUM_REGS);

   logic [IDX_W-1:0]    reg_idx;
   logic [NUM_REGS-1:0] reg_sel;
   logic                unused_dec;

   assign reg_idx    = addr[ADDR_W-1:2];
   assign unused_dec = ^{wdata, be, addr[1:0]};

   for (genvar m = 0; m < NUM_REGS; m++) begin : g_sel
      assign reg_sel[m] = wr_en && (reg_idx == IDX_W'(m));
   end

   for (genvar b = 0; b < NUM_LANES; b++) begin : g_lane
      for (genvar m = 0; m < NUM_REGS; m++) begin : g_reg
         localparam int SRC = source_id(b, m, NUM_REGS);
         assign we_src[SRC]   = reg_sel[m] & be[b];
         assign wval_src[SRC] = wdata[flag_bit_pos(b)];
      end
   end

   // R10: at most one register is selected per write
   p_one_reg_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_sel));
   // R10: no select without a write strobe
   p_no_sel_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> (reg_sel == '0));
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux #(
   parameter int NUM_REGS  = 32,
   parameter int NUM_LANES = 3,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 7,
   parameter bit RD_REG    = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rd_en,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [NUM_LANES*NUM_REGS-1:0] flags,
   output logic [DATA_W-1:0]             rdata
);
   import irq_pend_pkg::*;
   localparam int IDX_W = $clog2(NUM_REGS);

   logic [IDX_W-1:0]  reg_idx;
   logic [DATA_W-1:0] word;
   logic [DATA_W-1:0] rsvd_mask;

   assign reg_idx = addr[ADDR_W-1:2];

   always_comb begin
      word      = '0;
      rsvd_mask = '1;
      for (int b = 0; b < NUM_LANES; b++) begin
         word[flag_bit_pos(b)]      = flags[b*NUM_REGS + int'(reg_idx)];
         rsvd_mask[flag_bit_pos(b)] = 1'b0;
      end
   end

   if (RD_REG) begin : g_reg_rd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rdata <= '0;
         else if (rd_en) rdata <= word;
      end
      // R8: read data holds between reads
      p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_en |=> $stable(rdata));
   end else begin : g_comb_rd
      logic unused_rd;
      assign unused_rd = rd_en;
      assign rdata     = word;
   end

   // R7: reserved positions never read as 1
   p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & rsvd_mask) == '0);
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int NUM_REGS  = 32,
   parameter int NUM_LANES = 3,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 7,
   parameter int NUM_SRC   = 96,
   parameter bit RD_REG    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  hw_req,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W/8-1:0] be,
   output logic [DATA_W-1:0]   rdata,
   output logic [NUM_SRC-1:0]  pending
);
   import irq_pend_pkg::*;
   localparam int IDX_W = $clog2(NUM_REGS);

   if (NUM_SRC != NUM_LANES * NUM_REGS) begin : g_chk_src
      $error("NUM_SRC must equal NUM_LANES*NUM_REGS");
   end
   if (NUM_LANES < 1 || NUM_LANES > MAX_LANES || NUM_LANES * LANE_W > DATA_W) begin : g_chk_lane
      $error("NUM_LANES does not fit the data word");
   end
   if (DATA_W != 32) begin : g_chk_data
      $error("DATA_W must be 32");
   end
   if (ADDR_W != IDX_W + 2 || (1 << IDX_W) != NUM_REGS) begin : g_chk_addr
      $error("ADDR_W must be clog2(NUM_REGS)+2 with NUM_REGS a power of two");
   end

   logic [NUM_SRC-1:0] we_src;
   logic [NUM_SRC-1:0] wval_src;
   logic [NUM_SRC-1:0] flags;

   irq_wr_decode #(
      .NUM_REGS (NUM_REGS),
      .NUM_LANES(NUM_LANES),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W)
   ) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .be      (be),
      .we_src  (we_src),
      .wval_src(wval_src)
   );

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_flag
      irq_flag_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .hw_set(hw_req[s]),
         .sw_we (we_src[s]),
         .sw_val(wval_src[s]),
         .flag  (flags[s])
      );
   end

   irq_rd_mux #(
      .NUM_REGS (NUM_REGS),
      .NUM_LANES(NUM_LANES),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .RD_REG   (RD_REG)
   ) u_rd (
      .clk  (clk),
      .rst_n(rst_n),
      .rd_en(rd_en),
      .addr (addr),
      .flags(flags),
      .rdata(rdata)
   );

   assign pending = flags;

   // R1: reset leaves nothing pending
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (pending == '0));

   // R2: any hardware pulse shows up on the pending vector next cycle
   p_req_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_req != '0) |=> ((pending & $past(hw_req)) == $past(hw_req)));

   if (RD_REG) begin : g_rd_chk
      // R8: lane 0 of the read word follows the pre-edge flag of the addressed source
      p_rd_lane0_r8: assert property (@(posedge clk) disable iff (!rst_n)
         rd_en |=> (rdata[0] == $past(flags[addr[ADDR_W-1:2]])));
   end
endmodule

// File: tb/irq_pend_bank_tb_top.sv
module irq_pend_bank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [95:0] hw_req;
   logic        wr_en, rd_en;
   logic [6:0]  addr;
   logic [31:0] wdata;
   logic [3:0]  be;
   logic [31:0] rdata;
   logic [95:0] pending;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [95:0] model;

   always #2 clk = ~clk;

   irq_pend_bank dut_i (
      .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .be(be), .rdata(rdata), .pending(pending)
   );

   function automatic logic [31:0] word_of(input logic [95:0] f, input int idx);
      logic [31:0] w = '0;
      w[0]  = f[idx];
      w[8]  = f[32+idx];
      w[16] = f[64+idx];
      return w;
   endfunction

   function automatic logic [95:0] next_of(input logic [95:0] f, input logic [95:0] hw,
                                           input logic wr, input int idx,
                                           input logic [31:0] wd, input logic [3:0] b);
      logic [95:0] n = f;
      if (wr)
         for (int l = 0; l < 3; l++)
            if (b[l]) n[l*32+idx] = wd[l*8];
      return n | hw;
   endfunction

   task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one cycle: drive at negedge, update model at the edge, check at the next negedge
   task automatic cyc(input logic [95:0] hw, input logic wr, input logic rd,
                      input logic [6:0] a, input logic [31:0] wd, input logic [3:0] b);
      logic [31:0] exp_rd;
      int idx = int'(a[6:2]);
      exp_rd = word_of(model, idx);
      hw_req = hw; wr_en = wr; rd_en = rd; addr = a; wdata = wd; be = b;
      @(posedge clk);
      model = next_of(model, hw, wr, idx, wd, b);
      @(negedge clk);
      hw_req = '0; wr_en = 1'b0; rd_en = 1'b0;
      chk("R9 pending", pending, model);
      if (rd) chk("R8 read", {64'd0, rdata}, {64'd0, exp_rd});
   endtask

   task automatic rd(input int idx);
      cyc('0, 1'b0, 1'b1, 7'(idx*4), 32'd0, 4'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [95:0] h;
      rst_n = 1'b0; hw_req = '0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0; be = '0;
      model = '0;
      repeat (3) @(negedge clk);
      chk("R1 pending in reset", pending, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pending after reset", pending, '0);
      rd(5);
      chk("R1 read after reset", {64'd0, rdata}, '0);

      // R2: source 70 -> reg 6 bit 16
      h = '0; h[70] = 1'b1;
      cyc(h, 0, 0, 0, 0, 0);
      chk("R2 pending[70]", {95'd0, pending[70]}, 96'd1);
      rd(6);
      chk("R2 reg6 word", {64'd0, rdata}, {64'd0, 32'h0001_0000});

      // R3: sticky over idle cycles
      repeat (20) cyc('0, 0, 0, 0, 0, 0);
      chk("R3 still set", {95'd0, pending[70]}, 96'd1);

      // R4: lane 1 write of 1 to reg 3 sets source 35
      cyc('0, 1, 0, 7'h0C, 32'h0000_0100, 4'b0010);
      chk("R4 set src35", {95'd0, pending[35]}, 96'd1);
      // R4: full-word 0 to reg 6 clears source 70
      cyc('0, 1, 0, 7'h18, 32'h0, 4'b1111);
      chk("R4 clear src70", {95'd0, pending[70]}, 96'd0);

      // R5: set 10,42,74 then clear only lane 1
      cyc('0, 1, 0, 7'h28, 32'h0001_0101, 4'b0111);
      cyc('0, 1, 0, 7'h28, 32'h0, 4'b0010);
      rd(10);
      chk("R5 lanes kept", {64'd0, rdata}, {64'd0, 32'h0001_0001});

      // R6: pulse on 10 while clearing lane 0 of reg 10
      h = '0; h[10] = 1'b1;
      cyc(h, 1, 0, 7'h28, 32'h0, 4'b0001);
      chk("R6 set wins", {95'd0, pending[10]}, 96'd1);

      // R7: all-ones into reg 20, lane 3 alone into reg 21
      cyc('0, 1, 0, 7'h50, 32'hFFFF_FFFF, 4'b1111);
      rd(20);
      chk("R7 reserved read 0", {64'd0, rdata}, {64'd0, 32'h0001_0101});
      cyc('0, 1, 0, 7'h54, 32'hFFFF_FFFF, 4'b1000);
      rd(21);
      chk("R7 lane3 no effect", {64'd0, rdata}, '0);

      // R10: unaligned address hits reg 31 only
      cyc('0, 1, 0, 7'h7E, 32'h0000_0001, 4'b0001);
      chk("R10 src31 set", {95'd0, pending[31]}, 96'd1);
      chk("R10 src30 untouched", {95'd0, pending[30]}, 96'd0);

      // R8: hold between reads
      rd(31);
      cyc('0, 1, 0, 7'h7C, 32'h0, 4'b0001);
      chk("R8 rdata held", {64'd0, rdata}, {64'd0, 32'h0000_0001});

      // random phase
      void'($urandom(32'd20240611));
      for (int i = 0; i < 3000; i++) begin
         logic [95:0] hr;
         for (int s = 0; s < 96; s++) hr[s] = ($urandom % 24) == 0;
         cyc(hr, ($urandom % 3) == 0, $urandom % 2, 7'($urandom), $urandom, 4'($urandom));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule